// File: doc/BRIEF.md
# Idle Ordered-Set Elastic Rate Matcher

This block absorbs a small frequency offset between a byte lane's recovered clock and the local clock. Each lane has its own instance, so lanes neither share storage nor coordinate with each other. Each byte arrives on the write clock with a control flag. The byte is staged in a 20-entry elastic store and leaves on the read clock. The design is sized for offsets of up to ±100 PPM between the far-end transmitter and the local clock.

The lane's idle stream is made of two-byte ordered sets: a comma control byte followed by one fixed data byte. The fill level is corrected only by whole ordered sets, so the comma is never separated from the data byte that follows it. When the writer finds the store close to full, it discards one complete incoming ordered set. When the reader finds the store close to empty, it emits one extra ordered set right after a set it has just read. The block does nothing, and neither pointer moves, until an upstream stage reports that the lane has reached synchronization. Overflow and underflow are kept as sticky status flags.

Top module: `rate_matcher`

## Requirements
- R1: While reset is low and just after its release, rd_valid, ovf and unf are 0.
- R2: While sync_ok is low, no byte is accepted and rd_valid stays 0.
- R3: Bytes that are not part of an ordered set leave the block in arrival order, with value and control flag unchanged.
- R4: An ordered set is the comma byte 8'hBC with control flag 1 followed at once by the fill byte 8'h50 with control flag 0. When the writer has an ordered set completing and its view of the fill is 16 or more, it drops both bytes. Under a faster writer, fewer ordered sets come out than went in.
- R5: After the reader has output an ordered set and sees a fill of 4 or less, it emits 8'hBC (control 1) and then 8'h50 (control 0) without moving its pointer. Under a slower writer, more ordered sets come out than went in.
- R6: Every comma 8'hBC with control 1 on the output is followed in the next read cycle by a valid 8'h50 with control 0.
- R7: A byte that must be written while 20 entries are held is dropped and sets ovf. The fill never exceeds 20, and ovf stays at 1 until reset.
- R8: A read cycle that finds the store empty, with no insertion possible, sets unf. unf stays at 1 until reset.
- R9: After activation, reading starts once 10 entries are visible. From then on, rd_valid is 1 in every read cycle unless an underflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered write clock |
| rd_clk | input | 1 | Local read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sync_ok | input | 1 | Lane synchronized (write clock domain) |
| wr_data | input | 8 | Incoming byte |
| wr_k | input | 1 | Incoming control flag |
| rd_data | output | 8 | Outgoing byte |
| rd_k | output | 1 | Outgoing control flag |
| rd_valid | output | 1 | Outgoing byte is present this read cycle |
| ovf | output | 1 | Sticky overflow (write clock domain) |
| unf | output | 1 | Sticky underflow (read clock domain) |

## Verification
In the write domain, an ordered set can finish in the same cycle that the stored fill reaches the near-full level. Whether the buffer overflows then depends on whether deletion takes precedence over the write. This is provoked by running the writer several percent faster than the reader. One stream has sparse idles and another has dense idles. A third stream has no idles at all, so deletion can never rescue the buffer. The outcome is judged at the output: the data bytes must all come through in order and ovf must stay clear when idles are present. When idles are absent, ovf must rise. The slow-writer runs do the same on the read side, where insertion and underflow compete.

// File: rtl/rm_pkg.sv
`timescale 1ns/1ps
package rm_pkg;
    localparam logic [7:0] COMMA_CODE = 8'hBC;
    localparam logic [7:0] FILL_CODE  = 8'h50;

    typedef struct packed {
        logic       k;
        logic [7:0] b;
    } sym_t;

    function automatic logic is_comma(input sym_t s);
        return s.k && (s.b == COMMA_CODE);
    endfunction

    function automatic logic is_fill(input sym_t s);
        return !s.k && (s.b == FILL_CODE);
    endfunction
endpackage

// File: rtl/rm_gray_sync.sv
`timescale 1ns/1ps
module rm_gray_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_in;
            s2_q <= s1_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin_out[i] = ^s2_q[W-1:i];
    end
endmodule

// File: rtl/rm_store.sv
`timescale 1ns/1ps
module rm_store
    import rm_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int AW    = 5
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wsym,
    input  logic [AW-1:0] raddr,
    output sym_t          rsym
);
    sym_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wsym;
    end

    assign rsym = mem[raddr];
endmodule

// File: rtl/rm_wr_ctl.sv
`timescale 1ns/1ps
module rm_wr_ctl
    import rm_pkg::*;
#(
    parameter int DEPTH     = 20,
    parameter int NEAR_FULL = 16,
    parameter int AW        = 5,
    parameter int CW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_ok,
    input  sym_t          in_sym,
    input  logic [CW-1:0] rcnt,
    output logic          we,
    output logic [AW-1:0] waddr,
    output sym_t          wsym,
    output logic [CW-1:0] wgray,
    output logic [CW-1:0] wcnt,
    output logic          active,
    output logic          ovf
);
    typedef struct packed {
        logic          active;
        logic          hold_v;
        sym_t          hold;
        logic [AW-1:0] waddr;
        logic [CW-1:0] wcnt;
        logic [CW-1:0] wgray;
        logic          ovf;
    } wst_t;

    wst_t st_d, st_q;
    logic [CW-1:0] fill;

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        waddr = st_q.waddr;
        wsym  = st_q.hold;
        fill  = st_q.wcnt - rcnt;
        st_d.active = sync_ok;
        if (st_q.active) begin
            if (st_q.hold_v && is_comma(st_q.hold) && is_fill(in_sym)
                && fill >= CW'(NEAR_FULL)) begin
                st_d.hold_v = 1'b0;
            end else begin
                if (st_q.hold_v) begin
                    if (fill >= CW'(DEPTH)) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        we = 1'b1;
                        st_d.waddr = (st_q.waddr == AW'(DEPTH - 1)) ? '0 : st_q.waddr + AW'(1);
                        st_d.wcnt  = st_q.wcnt + CW'(1);
                    end
                end
                st_d.hold   = in_sym;
                st_d.hold_v = 1'b1;
            end
        end
        st_d.wgray = st_d.wcnt ^ (st_d.wcnt >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wgray  = st_q.wgray;
    assign wcnt   = st_q.wcnt;
    assign active = st_q.active;
    assign ovf    = st_q.ovf;
endmodule

// File: rtl/rm_rd_ctl.sv
`timescale 1ns/1ps
module rm_rd_ctl
    import rm_pkg::*;
#(
    parameter int DEPTH      = 20,
    parameter int NEAR_EMPTY = 4,
    parameter int START_LVL  = 10,
    parameter int AW         = 5,
    parameter int CW         = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wcnt,
    input  sym_t          rsym,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] rgray,
    output sym_t          out_sym,
    output logic          out_valid,
    output logic          unf,
    output logic          ins_busy
);
    typedef struct packed {
        logic          run;
        logic          ins;
        logic          os_end;
        logic          prev_comma;
        logic [AW-1:0] raddr;
        logic [CW-1:0] rcnt;
        logic [CW-1:0] rgray;
        sym_t          outs;
        logic          valid;
        logic          unf;
    } rst_t;

    rst_t st_d, st_q;
    logic [CW-1:0] fill;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        fill       = wcnt - st_q.rcnt;
        if (!st_q.run) begin
            if (fill >= CW'(START_LVL)) st_d.run = 1'b1;
        end else if (st_q.ins) begin
            st_d.outs       = '{k: 1'b0, b: FILL_CODE};
            st_d.valid      = 1'b1;
            st_d.ins        = 1'b0;
            st_d.os_end     = 1'b1;
            st_d.prev_comma = 1'b0;
        end else if (st_q.os_end && fill <= CW'(NEAR_EMPTY)) begin
            st_d.outs       = '{k: 1'b1, b: COMMA_CODE};
            st_d.valid      = 1'b1;
            st_d.ins        = 1'b1;
            st_d.os_end     = 1'b0;
            st_d.prev_comma = 1'b1;
        end else if (fill != '0) begin
            st_d.outs       = rsym;
            st_d.valid      = 1'b1;
            st_d.os_end     = st_q.prev_comma && is_fill(rsym);
            st_d.prev_comma = is_comma(rsym);
            st_d.raddr      = (st_q.raddr == AW'(DEPTH - 1)) ? '0 : st_q.raddr + AW'(1);
            st_d.rcnt       = st_q.rcnt + CW'(1);
        end else begin
            st_d.unf = 1'b1;
        end
        st_d.rgray = st_d.rcnt ^ (st_d.rcnt >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr     = st_q.raddr;
    assign rgray     = st_q.rgray;
    assign out_sym   = st_q.outs;
    assign out_valid = st_q.valid;
    assign unf       = st_q.unf;
    assign ins_busy  = st_q.ins;
endmodule

// File: rtl/rate_matcher.sv
`timescale 1ns/1ps
module rate_matcher
    import rm_pkg::*;
#(
    parameter int DEPTH      = 20,
    parameter int NEAR_FULL  = 16,
    parameter int NEAR_EMPTY = 4,
    parameter int START_LVL  = 10
) (
    input  logic       wr_clk,
    input  logic       rd_clk,
    input  logic       rst_n,
    input  logic       sync_ok,
    input  logic [7:0] wr_data,
    input  logic       wr_k,
    output logic [7:0] rd_data,
    output logic       rd_k,
    output logic       rd_valid,
    output logic       ovf,
    output logic       unf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr, raddr;
    sym_t          wsym, rsym, out_sym;
    logic [CW-1:0] wgray, rgray, wcnt_w, rcnt_w, wcnt_r;
    logic          w_active, r_ins;

    rm_wr_ctl #(.DEPTH(DEPTH), .NEAR_FULL(NEAR_FULL), .AW(AW), .CW(CW)) i_wr (
        .clk(wr_clk), .rst_n(rst_n), .sync_ok(sync_ok),
        .in_sym('{k: wr_k, b: wr_data}), .rcnt(rcnt_w),
        .we(we), .waddr(waddr), .wsym(wsym), .wgray(wgray), .wcnt(wcnt_w),
        .active(w_active), .ovf(ovf)
    );

    rm_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wsym(wsym),
        .raddr(raddr), .rsym(rsym)
    );

    rm_gray_sync #(.W(CW)) i_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wcnt_r)
    );

    rm_gray_sync #(.W(CW)) i_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rcnt_w)
    );

    rm_rd_ctl #(.DEPTH(DEPTH), .NEAR_EMPTY(NEAR_EMPTY), .START_LVL(START_LVL),
                .AW(AW), .CW(CW)) i_rd (
        .clk(rd_clk), .rst_n(rst_n), .wcnt(wcnt_r), .rsym(rsym),
        .raddr(raddr), .rgray(rgray), .out_sym(out_sym),
        .out_valid(rd_valid), .unf(unf), .ins_busy(r_ins)
    );

    assign rd_data = out_sym.b;
    assign rd_k    = out_sym.k;
endmodule

// File: rtl/rm_checker.sv
`timescale 1ns/1ps
module rm_checker #(
    parameter int DEPTH = 20,
    parameter int CW    = 6
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          w_active,
    input logic [CW-1:0] wcnt,
    input logic [CW-1:0] rcnt_w,
    input logic          ovf,
    input logic          unf,
    input logic          ins_busy,
    input logic          rd_valid,
    input logic          rd_k,
    input logic [7:0]    rd_data
);
    // R2: no pointer movement while not synchronized
    a_r2_frozen: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !w_active |=> $stable(wcnt));

    // R7: stored fill never above the depth
    a_r7_fill_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
        CW'(wcnt - rcnt_w) <= CW'(DEPTH));

    // R7: overflow flag is sticky
    a_r7_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R8: underflow flag is sticky
    a_r8_unf_sticky: assert property (@(posedge rd_clk) disable iff (!rst_n)
        unf |=> unf);

    // R6: an insertion starts with the comma on the output
    a_r6_ins_comma: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ins_busy |-> (rd_valid && rd_k && rd_data == 8'hBC));

    // R6: an insertion finishes with the fill byte in the next cycle
    a_r6_ins_fill: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ins_busy |=> (rd_valid && !rd_k && rd_data == 8'h50));
endmodule

bind rate_matcher rm_checker #(.DEPTH(DEPTH), .CW(CW)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .w_active(w_active), .wcnt(wcnt_w), .rcnt_w(rcnt_w),
    .ovf(ovf), .unf(unf), .ins_busy(r_ins),
    .rd_valid(rd_valid), .rd_k(rd_k), .rd_data(rd_data)
);

// File: tb/test_rate_matcher.sv
`timescale 1ns/1ps
module test_rate_matcher;
    // mode: 0 none, 1 deletion, 2 insertion, 3 overflow, 4 underflow
    typedef struct packed {
        int half_ps;
        int n_data;
        int n_idle;
        int mode;
    } scen_t;

    localparam int NSC  = 6;
    localparam int MAXB = 4096;
    localparam int NBYTES = 1200;
    localparam scen_t TBL [NSC] = '{
        '{2400, 8, 2, 1},
        '{2600, 8, 2, 2},
        '{2500, 8, 2, 0},
        '{2400, 8, 0, 3},
        '{2600, 8, 0, 4},
        '{2450, 2, 2, 1}
    };

    logic       wr_clk = 0, rd_clk = 0, rst_n = 0, sync_ok = 0, wr_k = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       rd_k, rd_valid, ovf, unf;
    realtime    wr_half = 2.5;

    rate_matcher i_rate_matcher (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .sync_ok(sync_ok),
        .wr_data(wr_data), .wr_k(wr_k), .rd_data(rd_data), .rd_k(rd_k),
        .rd_valid(rd_valid), .ovf(ovf), .unf(unf)
    );

    always #2.5 rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    int total = 0, bad = 0;
    logic [7:0] idata [MAXB];
    int ipairs_at [MAXB];
    int opairs_at [MAXB];
    int in_dn, in_pairs, out_dn, out_pairs, data_err, pair_err, gaps, valid_cnt;
    bit seen, prev_comma_o, mon_en = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge rd_clk) begin
        if (rd_valid) valid_cnt++;
        if (mon_en) begin
            if (rd_valid) begin
                seen = 1;
                if (prev_comma_o && !(!rd_k && rd_data == 8'h50)) pair_err++;
                prev_comma_o = rd_k && rd_data == 8'hBC;
                if (rd_k && rd_data == 8'hBC) out_pairs++;
                else if (!(!rd_k && rd_data == 8'h50)) begin
                    if (out_dn < MAXB) begin
                        if (rd_k || rd_data != idata[out_dn]) data_err++;
                        opairs_at[out_dn] = out_pairs;
                    end
                    out_dn++;
                end
            end else begin
                if (seen) gaps++;
                if (prev_comma_o) pair_err++;
                prev_comma_o = 0;
            end
        end
    end

    task automatic do_reset();
        rst_n = 0;
        sync_ok = 0;
        mon_en = 0;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1;
        in_dn = 0; in_pairs = 0; out_dn = 0; out_pairs = 0;
        data_err = 0; pair_err = 0; gaps = 0; valid_cnt = 0;
        seen = 0; prev_comma_o = 0;
        @(negedge rd_clk);
        check(rd_valid == 0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        check(ovf == 0, "R1", "ovf after reset", int'(ovf), 0);
        check(unf == 0, "R1", "unf after reset", int'(unf), 0);
    endtask

    task automatic run_stream(input int nbytes, input int nd, input int ni, input bit rec);
        int pos = 0;
        int dv = 0;
        for (int n = 0; n < nbytes; n++) begin
            @(negedge wr_clk);
            if (pos < 2 * ni) begin
                wr_k = (pos % 2 == 0);
                wr_data = (pos % 2 == 0) ? 8'hBC : 8'h50;
                if (rec && pos % 2 == 0) in_pairs++;
            end else begin
                wr_k = 0;
                wr_data = 8'(dv % 64);
                if (rec && in_dn < MAXB) begin
                    idata[in_dn] = 8'(dv % 64);
                    ipairs_at[in_dn] = in_pairs;
                    in_dn++;
                end
                dv++;
            end
            pos = (pos + 1 == 2 * ni + nd) ? 0 : pos + 1;
        end
    endtask

    initial begin
        repeat (190000) @(posedge rd_clk);
        check(0, "WD", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // directed: nothing happens before synchronization (R2)
        wr_half = 2.5;
        do_reset();
        run_stream(300, 8, 2, 0);
        check(valid_cnt == 0, "R2", "outputs before sync", valid_cnt, 0);
        check(ovf == 0 && unf == 0, "R2", "flags before sync", int'({ovf, unf}), 0);

        // table-driven scenarios
        for (int s = 0; s < NSC; s++) begin
            int k, ip, op;
            wr_half = real'(TBL[s].half_ps) / 1000.0;
            do_reset();
            @(negedge wr_clk);
            sync_ok = 1;
            mon_en = 1;
            run_stream(NBYTES, TBL[s].n_data, TBL[s].n_idle, 1);
            repeat (4) @(negedge rd_clk);
            mon_en = 0;
            k  = ((out_dn < MAXB) ? out_dn : MAXB) - 1;
            ip = (k >= 0) ? ipairs_at[k] : 0;
            op = (k >= 0) ? opairs_at[k] : 0;
            check(pair_err == 0, "R6", $sformatf("pair split scen %0d", s), pair_err, 0);
            check(ovf == (TBL[s].mode == 3), "R7", $sformatf("ovf scen %0d", s),
                  int'(ovf), int'(TBL[s].mode == 3));
            check(unf == (TBL[s].mode == 4), "R8", $sformatf("unf scen %0d", s),
                  int'(unf), int'(TBL[s].mode == 4));
            if (TBL[s].mode <= 2) begin
                check(out_dn > 200, "R9", $sformatf("data out scen %0d", s), out_dn, 201);
                check(data_err == 0, "R3", $sformatf("data order scen %0d", s), data_err, 0);
                check(gaps == 0, "R9", $sformatf("gaps scen %0d", s), gaps, 0);
            end
            if (TBL[s].mode == 1)
                check(op + 3 < ip, "R4", $sformatf("deletions scen %0d", s), op, ip);
            if (TBL[s].mode == 2)
                check(op > ip + 3, "R5", $sformatf("insertions scen %0d", s), op, ip);
            if (TBL[s].mode == 0)
                check(op <= ip + 3 && ip <= op + 3, "R4",
                      $sformatf("no adjust scen %0d", s), op, ip);
            if (TBL[s].mode == 3)
                check(gaps == 0, "R9", "reader steady under overflow", gaps, 0);
            if (TBL[s].mode == 4)
                check(gaps > 0, "R8", "underflow shows as gaps", gaps, 1);
        end

        // sticky flags cleared by reset (R7, R8, R1)
        wr_half = 2.5;
        do_reset();
        check(ovf == 0 && unf == 0, "R7", "sticky cleared by reset", int'({ovf, unf}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule